// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block is the digital side of a two-channel serial-input converter. A host lowers an active-low chip select and clocks a word in on a serial data line, most significant bit first. Each word carries a two-bit channel address and a data field of `DATA_W` bits, with the data justified to the MSB end. When chip select rises, the data field is written into the input register of each channel that the address selects. A separate active-low load strobe passes the input registers into the two DAC registers, and the DAC register words are the block's outputs.

All serial and strobe pins are sampled by a system clock through synchronizer chains, and their edges are found in the system clock domain. A power-on reset clears every register. A separate asynchronous clear pin forces the input and DAC registers either to zero or to midscale, depending on a select pin.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `cs_n` is high, edges on `sclk` leave the shift register unchanged, so a later frame with no clocks writes back the word held before those edges.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into the shift register. The word is sent MSB first and is `DATA_W+2` bits long: two address bits, then the data bits.
- R3: A rising edge of `cs_n` writes the data field (the low `DATA_W` bits of the shift register) into the input register of each addressed channel. The address is the top two bits: 01 selects channel A, 10 selects channel B, 11 selects both, and 00 writes nothing. Registers of channels that are not addressed keep their value.
- R4: While `ldac_n` is low, each DAC register follows its input register, one system clock behind it.
- R5: While `ldac_n` is high, the DAC registers hold their value. A rising edge of `ldac_n` latches them, and it changes neither the input registers nor the shift register.
- R6: While `clr_n` is low, the input and DAC registers of both channels are forced, without waiting for a clock, to 0 when `clr_mid` is 0 and to `1 << (DATA_W-1)` when `clr_mid` is 1. The shift register is not affected.
- R7: After power-on reset (`por_n` low), all input and DAC registers read zero.
- R8: A frame with the wrong number of clocks is still accepted. A long frame uses the last `DATA_W+2` bits. A short frame uses the earlier shift-register contents moved up by the number of new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| cs_n | input | 1 | Frame select, active low; its rising edge commits the frame |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Load strobe: low makes the DAC registers transparent, high holds them |
| clr_n | input | 1 | Asynchronous clear of the input and DAC registers, active low |
| clr_mid | input | 1 | Clear value select: 0 gives zero, 1 gives midscale |
| dac_a | output | DATA_W | DAC register word of channel A |
| dac_b | output | DATA_W | DAC register word of channel B |

## Verification
On every cycle the assertions check four things: the shift register is frozen while chip select is high and moves by exactly one place on a qualified serial edge; the input registers change only on a chip-select rising edge; the DAC registers hold while the load strobe is high and track the input registers while it is low; and a held clear shows the selected value. Several behaviours can only be shown by the bench's scenarios, because they need a whole sequence of pin activity before the outputs reveal them. These are the address decode across a full frame, the reuse of stale shift-register bits after short frames, long frames, and a clear that leaves the serial word in place for a later empty frame.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   localparam int ADDR_W = 2;
   localparam int NUM_CH = 2;

   typedef enum logic [ADDR_W-1:0] {
      ADDR_NONE = 2'b00,
      ADDR_A    = 2'b01,
      ADDR_B    = 2'b10,
      ADDR_BOTH = 2'b11
   } chan_addr_e;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
   parameter int               WIDTH  = 1,
   parameter int               STAGES = 2,
   parameter logic [WIDTH-1:0] INIT   = '0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               stage_q[s] <= INIT;
            end else begin
               stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/shift_frame.sv
module shift_frame #(
   parameter int FRAME_W = 18
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               shift_en,
   input  logic               bit_in,
   output logic [FRAME_W-1:0] word_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         word_q <= '0;
      end else if (shift_en) begin
         word_q <= {word_q[FRAME_W-2:0], bit_in};
      end
   end

endmodule

// File: rtl/chan_regs.sv
module chan_regs #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clr_n,
   input  logic [DATA_W-1:0] clr_val,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_open,
   output logic [DATA_W-1:0] inp_q,
   output logic [DATA_W-1:0] dac_q
);

   always_ff @(posedge clk or negedge por_n or negedge clr_n) begin
      if (!por_n) begin
         inp_q <= '0;
      end else if (!clr_n) begin
         inp_q <= clr_val;
      end else if (wr_en) begin
         inp_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge por_n or negedge clr_n) begin
      if (!por_n) begin
         dac_q <= '0;
      end else if (!clr_n) begin
         dac_q <= clr_val;
      end else if (load_open) begin
         dac_q <= inp_q;
      end
   end

endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
   import dacif_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              ldac_n,
   input  logic              clr_n,
   input  logic              clr_mid,
   output logic [DATA_W-1:0] dac_a,
   output logic [DATA_W-1:0] dac_b
);

   localparam int FRAME_W = DATA_W + ADDR_W;
   localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

   generate
      if (DATA_W != 14 && DATA_W != 16) begin : g_bad_width
         $error("dual_dac_serial_if: DATA_W must be 14 or 16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dual_dac_serial_if: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // synchronized pins: {sdi, sclk, cs_n, ldac_n}; chip select and load idle high
   logic [3:0] pins_s;
   logic       sdi_s, sclk_s, cs_s, ldac_s;
   logic       sclk_d, cs_d;
   logic       sclk_rise, cs_rise, shift_en;

   sync_chain #(
      .WIDTH (4),
      .STAGES(SYNC_STAGES),
      .INIT  (4'b0011)
   ) u_sync (
      .clk  (clk),
      .por_n(por_n),
      .d    ({sdi, sclk, cs_n, ldac_n}),
      .q    (pins_s)
   );

   assign {sdi_s, sclk_s, cs_s, ldac_s} = pins_s;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign cs_rise   = cs_s & ~cs_d;
   assign shift_en  = sclk_rise & ~cs_s;

   logic [FRAME_W-1:0] sr_q;

   shift_frame #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .por_n   (por_n),
      .shift_en(shift_en),
      .bit_in  (sdi_s),
      .word_q  (sr_q)
   );

   chan_addr_e         addr;
   logic [NUM_CH-1:0]  wr_en;
   logic [DATA_W-1:0]  clr_val;

   assign addr    = chan_addr_e'(sr_q[FRAME_W-1 -: ADDR_W]);
   assign clr_val = clr_mid ? MIDSCALE : '0;

   always_comb begin
      wr_en = '0;
      if (cs_rise) begin
         case (addr)
            ADDR_A:    wr_en = 2'b01;
            ADDR_B:    wr_en = 2'b10;
            ADDR_BOTH: wr_en = 2'b11;
            default:   wr_en = 2'b00;
         endcase
      end
   end

   logic [DATA_W-1:0] inp_w [NUM_CH];
   logic [DATA_W-1:0] dac_w [NUM_CH];

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
         chan_regs #(.DATA_W(DATA_W)) u_regs (
            .clk      (clk),
            .por_n    (por_n),
            .clr_n    (clr_n),
            .clr_val  (clr_val),
            .wr_en    (wr_en[ch]),
            .wr_data  (sr_q[DATA_W-1:0]),
            .load_open(~ldac_s),
            .inp_q    (inp_w[ch]),
            .dac_q    (dac_w[ch])
         );
      end
   endgenerate

   logic [DATA_W-1:0] inp_a_q, inp_b_q;
   assign inp_a_q = inp_w[0];
   assign inp_b_q = inp_w[1];
   assign dac_a   = dac_w[0];
   assign dac_b   = dac_w[1];

endmodule

// File: rtl/dual_dac_serial_if_chk.sv
module dual_dac_serial_if_chk #(
   parameter int DATA_W  = 16,
   parameter int FRAME_W = 18
) (
   input logic               clk,
   input logic               por_n,
   input logic               clr_n,
   input logic               clr_mid,
   input logic               cs_s,
   input logic               sclk_rise,
   input logic               cs_rise,
   input logic               ldac_s,
   input logic [FRAME_W-1:0] sr_q,
   input logic [DATA_W-1:0]  inp_a_q,
   input logic [DATA_W-1:0]  inp_b_q,
   input logic [DATA_W-1:0]  dac_a,
   input logic [DATA_W-1:0]  dac_b
);

   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   AST_SR_FROZEN_CS_HIGH: assert property (@(posedge clk) disable iff (!por_n)
      cs_s |=> $stable(sr_q)); // R1

   AST_SR_ONE_PLACE: assert property (@(posedge clk) disable iff (!por_n)
      (sclk_rise && !cs_s) |=> sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])); // R2

   AST_INP_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
      !cs_rise |=> ($stable(inp_a_q) && $stable(inp_b_q))); // R3

   AST_DAC_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
      !ldac_s |=> (dac_a == $past(inp_a_q) && dac_b == $past(inp_b_q))); // R4

   AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
      ldac_s |=> ($stable(dac_a) && $stable(dac_b))); // R5

   AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!por_n)
      (!clr_n && $past(!clr_n) && $stable(clr_mid)) |->
         (dac_a == (clr_mid ? MID : '0) && inp_b_q == (clr_mid ? MID : '0))); // R6

endmodule

bind dual_dac_serial_if dual_dac_serial_if_chk #(
   .DATA_W (DATA_W),
   .FRAME_W(FRAME_W)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .clr_n    (clr_n),
   .clr_mid  (clr_mid),
   .cs_s     (cs_s),
   .sclk_rise(sclk_rise),
   .cs_rise  (cs_rise),
   .ldac_s   (ldac_s),
   .sr_q     (sr_q),
   .inp_a_q  (inp_a_q),
   .inp_b_q  (inp_b_q),
   .dac_a    (dac_a),
   .dac_b    (dac_b)
);

// File: tb/sim_dual_dac_serial_if.sv
module sim_dual_dac_serial_if;

   localparam int W  = 16;
   localparam int FW = W + 2;
   localparam logic [W-1:0] MID = W'(1) << (W - 1);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic por_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic ldac_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
   logic [W-1:0] dac_a, dac_b;

   dual_dac_serial_if #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .por_n(por_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .ldac_n(ldac_n), .clr_n(clr_n), .clr_mid(clr_mid),
      .dac_a(dac_a), .dac_b(dac_b)
   );

   int n_run = 0, n_fail = 0;
   logic [FW-1:0] e_sr = '0;
   logic [W-1:0]  e_inp [2];
   logic [W-1:0]  e_dac [2];

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_out(input string req);
      check({req, " ch A"}, dac_a, e_dac[0]);
      check({req, " ch B"}, dac_b, e_dac[1]);
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [63:0] mk(input logic [1:0] a, input logic [W-1:0] d);
      return 64'({a, d});
   endfunction

   task automatic send_bits(input logic [63:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = bits[i];
         wait_clk(3);
         sclk = 1'b1;
         if (!cs_n) e_sr = {e_sr[FW-2:0], bits[i]};
         wait_clk(3);
         sclk = 1'b0;
         wait_clk(1);
      end
   endtask

   // R3 model: top two bits address (01 A, 10 B, 11 both, 00 none)
   task automatic cs_frame(input logic [63:0] bits, input int n);
      cs_n = 1'b0;
      wait_clk(4);
      send_bits(bits, n);
      wait_clk(3);
      cs_n = 1'b1;
      wait_clk(8);
      if (e_sr[FW-2]) e_inp[0] = e_sr[W-1:0];
      if (e_sr[FW-1]) e_inp[1] = e_sr[W-1:0];
      if (!ldac_n) begin
         e_dac[0] = e_inp[0];
         e_dac[1] = e_inp[1];
      end
   endtask

   task automatic set_ldac(input logic v);
      ldac_n = v;
      wait_clk(8);
      if (!v) begin
         e_dac[0] = e_inp[0];
         e_dac[1] = e_inp[1];
      end
   endtask

   task automatic do_clear(input logic mid);
      clr_mid = mid;
      wait_clk(1);
      clr_n = 1'b0;
      #1;
      e_inp[0] = mid ? MID : '0;
      e_inp[1] = e_inp[0];
      e_dac[0] = e_inp[0];
      e_dac[1] = e_inp[0];
      check("R6 immediate ch A", dac_a, e_dac[0]);
      wait_clk(4);
      check_out("R6 held");
      clr_n = 1'b1;
      wait_clk(6);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      e_inp[0] = '0; e_inp[1] = '0; e_dac[0] = '0; e_dac[1] = '0;
      wait_clk(3);
      por_n = 1'b1;
      wait_clk(4);
      check_out("R7 power-on");

      // R5: held load strobe blocks the write from the outputs
      cs_frame(mk(2'b01, 16'h1234), FW);
      check_out("R5 hold after write A");
      set_ldac(1'b0);
      check_out("R4 transparent shows A");

      // R4: with load open, writes flow through; R3 other channel untouched
      cs_frame(mk(2'b10, 16'hBEEF), FW);
      check_out("R4 R3 write B only");
      cs_frame(mk(2'b11, 16'h0F0F), FW);
      check_out("R3 write both");
      cs_frame(mk(2'b00, 16'hAAAA), FW);
      check_out("R3 no-op address");

      // R5: rising load latches; later write stays hidden, input kept
      set_ldac(1'b1);
      cs_frame(mk(2'b01, 16'h7777), FW);
      check_out("R5 latched after rise");
      set_ldac(1'b0);
      check_out("R5 input kept, shown on reopen");

      // R8: long frame keeps the last FW bits
      cs_frame({41'h0, 5'b10110, 2'b10, 16'hC3A5}, FW + 5);
      check_out("R8 long frame");
      // R8: short frame reuses shifted stale bits
      cs_frame(64'b01101, 5);
      check_out("R8 short frame");

      // R6 + R1: clear leaves shift reg; clocks with cs high do not shift
      cs_frame(mk(2'b01, 16'h5A5A), FW);
      do_clear(1'b0);
      set_ldac(1'b0);
      send_bits(64'h3_FFFF, FW);
      cs_frame(64'h0, 0);
      check_out("R1 R6 empty frame rewrites kept word");
      do_clear(1'b1);
      set_ldac(1'b1);
      set_ldac(1'b0);
      check_out("R6 midscale in input regs");

      // constrained random frames: R2 R3 R4 R5
      for (int k = 0; k < 40; k++) begin
         logic [1:0] a;
         logic [W-1:0] d;
         a = 2'($urandom % 4);
         d = W'($urandom);
         set_ldac(1'(($urandom % 3) == 0));
         cs_frame(mk(a, d), FW);
         check_out(ldac_n ? "R2 R3 R5 random" : "R2 R3 R4 random");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule